// File: doc/BRIEF.md
# Clock and Power Mode Sequencer

This block sits between software and an external clock unit. It holds a two-bit clock configuration register and takes power mode commands on a separate write strobe. From these it sequences the core into one of four actions: entering or leaving turbo mode, a frequency change (which can retarget turbo in the same write), idle, or sleep. Each register write or valid power mode write becomes one command. The sequencer does not let a command reach the clock unit while the core still has memory requests in flight. It waits for an externally supplied outstanding-request count to reach zero, then raises the matching request output for exactly one cycle. After that it stays busy until the clock unit reports completion. For sleep, completion is the sleep-exit indication.

While a command is in progress, any further command is dropped and a sticky error flag is raised. The configuration bits return to zero on any of the following:
- the asynchronous hardware reset;
- a synchronous watchdog reset or pin reset;
- sleep exit.

The frequency-change bit also clears by itself when its sequence completes. A later read-modify-write therefore cannot start a second sequence by accident.

Top module: `clk_pwr_seq`

## Requirements
- R1: After hardware reset, the register reads zero, every request output is low, and `busy`, `cmd_err` and `turbo_lvl` are low.
- R2: In the register, bit 0 is turbo and bit 1 is the frequency-change bit. All higher read bits are zero, and written values of the higher bits are ignored.
- R3: A write that is accepted with bit 1 = 0 stores both bits and produces a turbo request. `turbo_lvl` follows bit 0 from the cycle after the write (1 = enter turbo, 0 = leave turbo).
- R4: A write that is accepted with bit 1 = 1 produces only a frequency-change request. The write's bit 0 sets `turbo_lvl` at the same time.
- R5: Power mode code 1 produces an idle request and code 3 produces a sleep request. Codes 0 and 2 start nothing, do not assert `busy`, and do not set `cmd_err`.
- R6: No request is issued while `mem_pending` is nonzero. When `mem_pending` is zero and no wait is needed, the request appears in the second cycle after the command is accepted. Otherwise it appears in the cycle after the edge at which the sequencer sees `mem_pending` reach zero.
- R7: Each command gives exactly one request pulse, one cycle long. At most one request output is high at any time.
- R8: `busy` stays high from acceptance until completion. For a non-sleep command, completion is `seq_done`; for a sleep command it is `sleep_exit`, and `seq_done` does not end a sleep. A register or valid power mode write while busy is ignored, and a power mode write in the same cycle as a register write is ignored (the register write wins). Either case sets the sticky `cmd_err`.
- R9: When a frequency-change sequence completes, bit 1 clears and bit 0 is kept.
- R10: A `sleep_exit` pulse clears both register bits.
- R11: A one-cycle `wdt_rst` or `pin_rst` clears both bits and `cmd_err`, and returns the sequencer to not busy. The request in progress is abandoned and is not reissued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wdt_rst | input | 1 | Synchronous watchdog reset, active high |
| pin_rst | input | 1 | Synchronous pin-triggered reset, active high |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | DATA_W | Register write data |
| cfg_rd_data | output | DATA_W | Register read data |
| pm_wr_en | input | 1 | Power mode write strobe |
| pm_code | input | 2 | Power mode code (1 idle, 3 sleep) |
| mem_pending | input | CNT_W | Count of core memory requests in flight |
| seq_done | input | 1 | Completion pulse from the clock unit |
| sleep_exit | input | 1 | Sleep-exit pulse from the clock unit |
| turbo_req | output | 1 | One-cycle turbo entry/exit request |
| fcs_req | output | 1 | One-cycle frequency-change request |
| idle_req | output | 1 | One-cycle idle request |
| sleep_req | output | 1 | One-cycle sleep request |
| turbo_lvl | output | 1 | Current turbo bit |
| busy | output | 1 | A command is in progress |
| cmd_err | output | 1 | Sticky flag for a dropped command |

## Verification
If the stored command kind is wrong, the wrong request output rises in the second cycle after acceptance, which is where the bench samples. If the drain state is skipped or left too early, a request shows up while `mem_pending` is nonzero, within one cycle of acceptance. If the completion state is wrong, `busy` either stays high after `seq_done` or drops after `seq_done` during a sleep, and this is visible one cycle after the pulse. If a clear path is missing, read data holds a stale 1 in the cycle after `sleep_exit`, after completion of a frequency change, or after a reset pulse.

// File: rtl/cpm_pkg.sv
package cpm_pkg;

  localparam int TURBO_BIT = 0;
  localparam int FCS_BIT   = 1;
  localparam int CFG_BITS  = 2;

  localparam logic [1:0] PM_IDLE  = 2'd1;
  localparam logic [1:0] PM_SLEEP = 2'd3;

  typedef enum logic [1:0] {
    CMD_TURBO = 2'd0,
    CMD_FCS   = 2'd1,
    CMD_IDLE  = 2'd2,
    CMD_SLEEP = 2'd3
  } cmd_kind_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_ISSUE = 2'd2,
    ST_WAIT  = 2'd3
  } seq_state_e;

endpackage

// File: rtl/cpm_cmd_dec.sv
module cpm_cmd_dec
  import cpm_pkg::*;
(
  input  logic                cfg_wr_en,
  input  logic [CFG_BITS-1:0] cfg_bits,
  input  logic                pm_wr_en,
  input  logic [1:0]          pm_code,
  input  logic                busy,
  output logic                cmd_valid,
  output cmd_kind_e           cmd_kind,
  output logic                cfg_accept,
  output logic                cmd_reject
);

  logic pm_start;
  logic pm_accept;

  // Only the idle and sleep codes start anything.
  assign pm_start   = pm_wr_en && ((pm_code == PM_IDLE) || (pm_code == PM_SLEEP));
  assign cfg_accept = cfg_wr_en && !busy;
  assign pm_accept  = pm_start && !busy && !cfg_wr_en;
  assign cmd_valid  = cfg_accept || pm_accept;

  always_comb begin
    if (cfg_wr_en) begin
      cmd_kind = cfg_bits[FCS_BIT] ? CMD_FCS : CMD_TURBO;
    end else if (pm_code == PM_SLEEP) begin
      cmd_kind = CMD_SLEEP;
    end else begin
      cmd_kind = CMD_IDLE;
    end
  end

  // Dropped commands: anything while busy, or a power write colliding with a register write.
  assign cmd_reject = (busy && (cfg_wr_en || pm_start)) || (cfg_wr_en && pm_start);

endmodule

// File: rtl/cpm_cfg_reg.sv
module cpm_cfg_reg
  import cpm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  logic                wr_accept,
  input  logic [CFG_BITS-1:0] wr_bits,
  input  logic                sleep_exit,
  input  logic                fcs_clr,
  output logic [DATA_W-1:0]   rd_data,
  output logic                turbo_o
);

  logic turbo_q, turbo_d;
  logic fcs_q, fcs_d;
  logic reg_en;

  always_comb begin
    turbo_d = turbo_q;
    fcs_d   = fcs_q;
    if (soft_rst) begin
      turbo_d = 1'b0;
      fcs_d   = 1'b0;
    end else if (wr_accept) begin
      turbo_d = wr_bits[TURBO_BIT];
      fcs_d   = wr_bits[FCS_BIT];
    end else if (sleep_exit) begin
      turbo_d = 1'b0;
      fcs_d   = 1'b0;
    end else if (fcs_clr) begin
      fcs_d   = 1'b0;
    end
  end

  assign reg_en = soft_rst || wr_accept || sleep_exit || fcs_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      turbo_q <= 1'b0;
      fcs_q   <= 1'b0;
    end else if (reg_en) begin
      turbo_q <= turbo_d;
      fcs_q   <= fcs_d;
    end
  end

  always_comb begin
    rd_data            = '0;
    rd_data[TURBO_BIT] = turbo_q;
    rd_data[FCS_BIT]   = fcs_q;
  end

  assign turbo_o = turbo_q;

  AST_SLEEP_EXIT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_exit && !wr_accept) |=> (!turbo_q && !fcs_q)); // R10

  AST_FCS_AUTO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (fcs_clr && !wr_accept && !soft_rst) |=> (!fcs_q && $stable(turbo_q))); // R9

  AST_SOFT_RST_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!turbo_q && !fcs_q)); // R11

endmodule

// File: rtl/cpm_seq_fsm.sv
module cpm_seq_fsm
  import cpm_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             cmd_valid,
  input  cmd_kind_e        cmd_kind,
  input  logic             cmd_reject,
  input  logic [CNT_W-1:0] mem_pending,
  input  logic             seq_done,
  input  logic             sleep_exit,
  output logic             turbo_req,
  output logic             fcs_req,
  output logic             idle_req,
  output logic             sleep_req,
  output logic             busy,
  output logic             err,
  output logic             fcs_clr
);

  seq_state_e state_q, state_d;
  cmd_kind_e  kind_q;
  logic       kind_en;
  logic       err_q, err_d;
  logic       drained;
  logic       done;
  logic       issuing;

  assign drained = (mem_pending == '0);
  // Sleep ends only on the exit indication; other commands end on the completion pulse.
  assign done    = (kind_q == CMD_SLEEP) ? sleep_exit : seq_done;
  assign kind_en = (state_q == ST_RUN) && cmd_valid && !soft_rst;

  always_comb begin
    state_d = state_q;
    err_d   = err_q;
    if (cmd_reject) begin
      err_d = 1'b1;
    end
    case (state_q)
      ST_RUN:   if (cmd_valid) state_d = ST_DRAIN;
      ST_DRAIN: if (drained)   state_d = ST_ISSUE;
      ST_ISSUE:                state_d = ST_WAIT;
      ST_WAIT:  if (done)      state_d = ST_RUN;
      default:                 state_d = ST_RUN;
    endcase
    if (soft_rst) begin
      state_d = ST_RUN;
      err_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= CMD_TURBO;
    end else if (kind_en) begin
      kind_q <= cmd_kind;
    end
  end

  assign issuing   = (state_q == ST_ISSUE);
  assign turbo_req = issuing && (kind_q == CMD_TURBO);
  assign fcs_req   = issuing && (kind_q == CMD_FCS);
  assign idle_req  = issuing && (kind_q == CMD_IDLE);
  assign sleep_req = issuing && (kind_q == CMD_SLEEP);
  assign busy      = (state_q != ST_RUN);
  assign err       = err_q;
  assign fcs_clr   = (state_q == ST_WAIT) && (kind_q == CMD_FCS) && seq_done;

  AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({turbo_req, fcs_req, idle_req, sleep_req})); // R7

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (turbo_req || fcs_req || idle_req || sleep_req) |=>
      !(turbo_req || fcs_req || idle_req || sleep_req)); // R7

  AST_NO_ISSUE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (turbo_req || fcs_req || idle_req || sleep_req) |-> ($past(mem_pending) == '0)); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !soft_rst) |=> err); // R8

  AST_REJECT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_reject && !soft_rst) |=> err); // R8

  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_WAIT) && (kind_q == CMD_SLEEP) && !sleep_exit && !soft_rst) |=> busy); // R8

  AST_SOFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!busy && !err)); // R11

endmodule

// File: rtl/clk_pwr_seq.sv
module clk_pwr_seq
  import cpm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wdt_rst,
  input  logic              pin_rst,
  input  logic              cfg_wr_en,
  input  logic [DATA_W-1:0] cfg_wr_data,
  output logic [DATA_W-1:0] cfg_rd_data,
  input  logic              pm_wr_en,
  input  logic [1:0]        pm_code,
  input  logic [CNT_W-1:0]  mem_pending,
  input  logic              seq_done,
  input  logic              sleep_exit,
  output logic              turbo_req,
  output logic              fcs_req,
  output logic              idle_req,
  output logic              sleep_req,
  output logic              turbo_lvl,
  output logic              busy,
  output logic              cmd_err
);

  logic                soft_rst;
  logic [CFG_BITS-1:0] cfg_bits;
  logic                unused_rsvd;
  logic                cmd_valid;
  cmd_kind_e           cmd_kind;
  logic                cfg_accept;
  logic                cmd_reject;
  logic                fcs_clr;
  logic                busy_int;

  assign soft_rst    = wdt_rst || pin_rst;
  assign cfg_bits    = cfg_wr_data[CFG_BITS-1:0];
  assign unused_rsvd = ^cfg_wr_data[DATA_W-1:CFG_BITS];

  cpm_cmd_dec u_dec (
    .cfg_wr_en  (cfg_wr_en),
    .cfg_bits   (cfg_bits),
    .pm_wr_en   (pm_wr_en),
    .pm_code    (pm_code),
    .busy       (busy_int),
    .cmd_valid  (cmd_valid),
    .cmd_kind   (cmd_kind),
    .cfg_accept (cfg_accept),
    .cmd_reject (cmd_reject)
  );

  cpm_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .wr_accept  (cfg_accept),
    .wr_bits    (cfg_bits),
    .sleep_exit (sleep_exit),
    .fcs_clr    (fcs_clr),
    .rd_data    (cfg_rd_data),
    .turbo_o    (turbo_lvl)
  );

  cpm_seq_fsm #(.CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .cmd_valid   (cmd_valid),
    .cmd_kind    (cmd_kind),
    .cmd_reject  (cmd_reject),
    .mem_pending (mem_pending),
    .seq_done    (seq_done),
    .sleep_exit  (sleep_exit),
    .turbo_req   (turbo_req),
    .fcs_req     (fcs_req),
    .idle_req    (idle_req),
    .sleep_req   (sleep_req),
    .busy        (busy_int),
    .err         (cmd_err),
    .fcs_clr     (fcs_clr)
  );

  assign busy = busy_int;

endmodule

// File: tb/clk_pwr_seq_test.sv
module clk_pwr_seq_test;

  localparam int DW = 32;
  localparam int CW = 4;

  logic          clk;
  logic          rst_n;
  logic          wdt_rst;
  logic          pin_rst;
  logic          cfg_wr_en;
  logic [DW-1:0] cfg_wr_data;
  logic [DW-1:0] cfg_rd_data;
  logic          pm_wr_en;
  logic [1:0]    pm_code;
  logic [CW-1:0] mem_pending;
  logic          seq_done;
  logic          sleep_exit;
  logic          turbo_req, fcs_req, idle_req, sleep_req;
  logic          turbo_lvl, busy, cmd_err;
  logic [3:0]    reqv;

  int checks = 0;
  int errors = 0;

  clk_pwr_seq #(.DATA_W(DW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .wdt_rst(wdt_rst), .pin_rst(pin_rst),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
    .pm_wr_en(pm_wr_en), .pm_code(pm_code), .mem_pending(mem_pending),
    .seq_done(seq_done), .sleep_exit(sleep_exit),
    .turbo_req(turbo_req), .fcs_req(fcs_req), .idle_req(idle_req), .sleep_req(sleep_req),
    .turbo_lvl(turbo_lvl), .busy(busy), .cmd_err(cmd_err)
  );

  // request vector: bit0 turbo, bit1 fcs, bit2 idle, bit3 sleep
  assign reqv = {sleep_req, idle_req, fcs_req, turbo_req};

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [31:0] d);
    cfg_wr_data = d;
    cfg_wr_en   = 1'b1;
    @(negedge clk);
    cfg_wr_en   = 1'b0;
  endtask

  task automatic pm_write(input logic [1:0] c);
    pm_code  = c;
    pm_wr_en = 1'b1;
    @(negedge clk);
    pm_wr_en = 1'b0;
  endtask

  task automatic pulse_done();
    seq_done = 1'b1;
    @(negedge clk);
    seq_done = 1'b0;
  endtask

  task automatic pulse_exit();
    sleep_exit = 1'b1;
    @(negedge clk);
    sleep_exit = 1'b0;
  endtask

  task automatic capture(input int n, output int first, output int hits,
                         output logic [3:0] seen, output int multi);
    first = -1; hits = 0; seen = 4'b0; multi = 0;
    for (int i = 0; i < n; i++) begin
      if (reqv != 4'b0) begin
        if (first < 0) first = i;
        hits++;
        seen = seen | reqv;
        if ($countones(reqv) > 1) multi++;
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; wdt_rst = 0; pin_rst = 0; cfg_wr_en = 0; cfg_wr_data = '0;
    pm_wr_en = 0; pm_code = 0; mem_pending = '0; seq_done = 0; sleep_exit = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rd_data", cfg_rd_data, 0);
    chk("R1 requests", {28'b0, reqv}, 0);
    chk("R1 busy", {31'b0, busy}, 0);
    chk("R1 cmd_err", {31'b0, cmd_err}, 0);
    chk("R1 turbo_lvl", {31'b0, turbo_lvl}, 0);
  endtask

  task automatic t_turbo();
    int f, h, m; logic [3:0] s;
    cfg_write(32'hFFFF_FFFD);
    chk("R2 reserved bits read zero", cfg_rd_data, 32'h1);
    chk("R3 turbo_lvl enter", {31'b0, turbo_lvl}, 1);
    capture(4, f, h, s, m);
    chk("R3 turbo request kind", {28'b0, s}, 4'b0001);
    chk("R6 issue latency no drain", f, 1);
    chk("R7 single pulse", h, 1);
    chk("R7 one-hot", m, 0);
    chk("R8 busy before done", {31'b0, busy}, 1);
    pulse_done();
    chk("R8 busy cleared by done", {31'b0, busy}, 0);
    cfg_write(32'hFFFF_FFFC);
    chk("R2 reserved write ignored", cfg_rd_data, 32'h0);
    chk("R3 turbo_lvl exit", {31'b0, turbo_lvl}, 0);
    capture(4, f, h, s, m);
    chk("R3 turbo exit request", {28'b0, s}, 4'b0001);
    pulse_done();
  endtask

  task automatic t_fcs();
    int f, h, m; logic [3:0] s;
    cfg_write(32'h3);
    chk("R4 readback fcs+turbo", cfg_rd_data, 32'h3);
    chk("R4 turbo_lvl with fcs", {31'b0, turbo_lvl}, 1);
    capture(4, f, h, s, m);
    chk("R4 fcs request only", {28'b0, s}, 4'b0010);
    chk("R7 fcs single pulse", h, 1);
    pulse_done();
    chk("R9 fcs auto clear keeps turbo", cfg_rd_data, 32'h1);
    chk("R9 idle after fcs", {31'b0, busy}, 0);
    cfg_write(32'h2);
    chk("R4 turbo cleared with fcs", {31'b0, turbo_lvl}, 0);
    capture(4, f, h, s, m);
    chk("R4 fcs request second", {28'b0, s}, 4'b0010);
    pulse_done();
    chk("R9 fcs cleared again", cfg_rd_data, 32'h0);
  endtask

  task automatic t_pm();
    int f, h, m; logic [3:0] s;
    pm_write(2'd0);
    chk("R5 code 0 not busy", {31'b0, busy}, 0);
    capture(4, f, h, s, m);
    chk("R5 code 0 no request", h, 0);
    pm_write(2'd2);
    chk("R5 code 2 not busy", {31'b0, busy}, 0);
    capture(4, f, h, s, m);
    chk("R5 code 2 no request", h, 0);
    chk("R5 no-op no error", {31'b0, cmd_err}, 0);
    pm_write(2'd1);
    capture(4, f, h, s, m);
    chk("R5 idle request", {28'b0, s}, 4'b0100);
    pulse_done();
    cfg_write(32'h1);
    capture(4, f, h, s, m);
    pulse_done();
    pm_write(2'd3);
    capture(4, f, h, s, m);
    chk("R5 sleep request", {28'b0, s}, 4'b1000);
    chk("R6 sleep latency", f, 1);
    pulse_done();
    chk("R8 done does not end sleep", {31'b0, busy}, 1);
    chk("R10 bits kept before exit", cfg_rd_data, 32'h1);
    pulse_exit();
    chk("R8 sleep exit ends busy", {31'b0, busy}, 0);
    chk("R10 sleep exit clears bits", cfg_rd_data, 32'h0);
  endtask

  task automatic t_drain();
    int f, h, m; logic [3:0] s;
    mem_pending = 4'd5;
    cfg_write(32'h1);
    capture(6, f, h, s, m);
    chk("R6 held while 5 pending", h, 0);
    mem_pending = 4'd2;
    capture(3, f, h, s, m);
    chk("R6 held while 2 pending", h, 0);
    mem_pending = 4'd0;
    capture(4, f, h, s, m);
    chk("R6 issue after drain", f, 1);
    chk("R6 drained kind", {28'b0, s}, 4'b0001);
    chk("R7 drained single pulse", h, 1);
    pulse_done();
  endtask

  task automatic t_busy();
    int f, h, m; logic [3:0] s;
    mem_pending = 4'd1;
    pm_write(2'd1);
    chk("R8 no error yet", {31'b0, cmd_err}, 0);
    cfg_write(32'h3);
    chk("R8 busy write ignored", cfg_rd_data, 32'h1);
    chk("R8 error set", {31'b0, cmd_err}, 1);
    pm_write(2'd3);
    mem_pending = 4'd0;
    capture(5, f, h, s, m);
    chk("R8 only first command issued", {28'b0, s}, 4'b0100);
    chk("R8 one request total", h, 1);
    pulse_done();
    capture(4, f, h, s, m);
    chk("R8 dropped command never issued", h, 0);
    chk("R8 error sticky", {31'b0, cmd_err}, 1);
  endtask

  task automatic t_soft();
    int f, h, m; logic [3:0] s;
    wdt_rst = 1'b1;
    @(negedge clk);
    wdt_rst = 1'b0;
    chk("R11 watchdog clears bits", cfg_rd_data, 32'h0);
    chk("R11 watchdog clears error", {31'b0, cmd_err}, 0);
    pm_write(2'd3);
    capture(3, f, h, s, m);
    chk("R11 sleep issued before pin reset", {28'b0, s}, 4'b1000);
    pin_rst = 1'b1;
    @(negedge clk);
    pin_rst = 1'b0;
    chk("R11 pin reset ends busy", {31'b0, busy}, 0);
    capture(4, f, h, s, m);
    chk("R11 no reissue after pin reset", h, 0);
    cfg_write(32'h1);
    capture(4, f, h, s, m);
    pulse_done();
    pin_rst = 1'b1;
    @(negedge clk);
    pin_rst = 1'b0;
    chk("R11 pin reset clears bits", cfg_rd_data, 32'h0);
  endtask

  task automatic t_collide();
    int f, h, m; logic [3:0] s;
    cfg_wr_data = 32'h3; cfg_wr_en = 1'b1;
    pm_code = 2'd3;      pm_wr_en = 1'b1;
    @(negedge clk);
    cfg_wr_en = 1'b0; pm_wr_en = 1'b0;
    chk("R8 collision register write wins", cfg_rd_data, 32'h3);
    chk("R8 collision flags error", {31'b0, cmd_err}, 1);
    capture(4, f, h, s, m);
    chk("R8 collision issues fcs only", {28'b0, s}, 4'b0010);
    pulse_done();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_turbo();
    t_fcs();
    t_pm();
    t_drain();
    t_busy();
    t_soft();
    t_collide();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule